// File: doc/BRIEF.md
# Per-Tenant Header Field Parser

This block turns the front of a packet into a packet header vector (PHV) that the match-action stages further down the pipeline can work on. It takes the first 1024 bits of a packet, the packet's VLAN ID and a sideband word. The low bits of the VLAN ID select that tenant's row of parse actions. Each action names a starting byte, a container size and a container slot. The chosen bytes are copied, in wire order, into the container that the action names.

The result is a 1024-bit vector. It holds 8 six-byte, 8 four-byte and 8 two-byte header containers, followed by a 256-bit metadata field. The metadata field carries the VLAN ID, a discard flag and the sideband word.

The control path loads parse-action rows through a separate write port. That port never holds up the data path. Packets enter and leave through valid/ready handshakes, and the pipeline has a fixed latency of two cycles.

Top module: `prs_hdr_parser`

## Requirements
- R1: After reset `out_valid_o` is 0 and `in_ready_o` is 1, and every table row is all zeros, so every action in it is invalid.
- R2: A packet accepted in cycle c (`in_valid_i` and `in_ready_o` both high) appears on `out_valid_o` in cycle c+2 when `out_ready_i` is held high. Packets leave in the order they were accepted.
- R3: A parse action is 16 bits: [15:13] ignored, [12:6] start byte offset, [5:4] size class, [3:1] container slot, [0] valid. Byte 0 is `pkt_i[1023:1016]` and byte k is `pkt_i[1023-8k -: 8]`. The first extracted byte lands in the most significant byte of the container.
- R4: Size class 2'b01 fills a 2-byte container, 2'b10 a 4-byte one and 2'b11 a 6-byte one. Size class 2'b00 fills nothing.
- R5: `phv_o` bit layout: the 6-byte container for slot i is at [640+48i +: 48], the 4-byte container at [384+32i +: 32] and the 2-byte container at [256+16i +: 16]. The metadata is at [255:0].
- R6: An action whose valid bit is 0 has no effect. A container that no valid action targets reads as zero.
- R7: Metadata: [140:129] holds `vid_i`, [128] holds `drop_i` (1 means drop), [127:0] holds `usr_i`, and [255:141] is zero.
- R8: The table row is chosen by `vid_i[3:0]`. The upper VLAN ID bits do not affect the row choice. Each row holds 10 actions, with action n at row bits [16n+15:16n].
- R9: A row written with `cfg_we_i` applies to packets accepted in later cycles. A write never lowers `in_ready_o`.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `phv_o` stays stable.
- R11: Bytes at offsets past byte 127 read as zero.
- R12: When several valid actions target the same container, the highest-numbered action wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Packet input valid |
| in_ready_o | output | 1 | Packet input ready |
| pkt_i | input | 1024 | First 1024 bits of the packet, byte 0 in the top bits |
| vid_i | input | 12 | VLAN ID of the packet |
| usr_i | input | 128 | Per-packet sideband word |
| drop_i | input | 1 | Discard flag copied into metadata |
| cfg_we_i | input | 1 | Table row write strobe |
| cfg_idx_i | input | 4 | Table row to write |
| cfg_row_i | input | 160 | Ten parse actions for the row |
| out_valid_o | output | 1 | PHV output valid |
| out_ready_i | input | 1 | PHV output ready |
| phv_o | output | 1024 | Assembled packet header vector |

## Verification
The assertions check four things on every cycle:
- the output holds stable under backpressure;
- an accepted packet always moves into the middle stage;
- a table write never drops input ready;
- the reserved metadata bits stay zero.

The correctness of the extracted bytes can only be shown by the scoreboard scenarios. These cover slot placement, size classes, invalid and size-less actions, overlapping targets, the read-as-zero tail past byte 127 and row selection by the low VLAN ID bits. Those scenarios also measure the exact two-cycle latency and show that a rewritten row reaches only the packets that follow it.

// File: rtl/prs_pkg.sv
package prs_pkg;

  typedef enum logic [1:0] {
    SZ_NONE = 2'b00,
    SZ_2B   = 2'b01,
    SZ_4B   = 2'b10,
    SZ_6B   = 2'b11
  } cont_sz_e;

  // field order is fixed by the action encoding
  typedef struct packed {
    logic [2:0] rsvd;
    logic [6:0] off;
    cont_sz_e   sz;
    logic [2:0] slot;
    logic       vld;
  } parse_act_t;

  localparam int unsigned ACT_W  = $bits(parse_act_t);
  localparam int unsigned WIN_W  = 48;
  localparam int unsigned SLOT_W = 3;

endpackage

// File: rtl/prs_act_tbl.sv
module prs_act_tbl #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned ROW_W = 160,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [ROW_W-1:0] wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [ROW_W-1:0] rdata_o
);

  logic [ROW_W-1:0] mem_q [DEPTH];

  // write port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // read port, old data on same-cycle collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end

endmodule

// File: rtl/prs_field_pick.sv
module prs_field_pick
  import prs_pkg::*;
#(
  parameter int unsigned PKT_W = 1024
) (
  input  parse_act_t        act_i,
  input  logic [PKT_W-1:0]  pkt_i,
  output logic              hit_o,
  output cont_sz_e          sz_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [WIN_W-1:0]  win_o
);

  logic [PKT_W-1:0] shifted;

  // bytes shifted out past the end come back as zero
  assign shifted = pkt_i << {act_i.off, 3'b000};
  assign win_o   = shifted[PKT_W-1 -: WIN_W];
  assign hit_o   = act_i.vld && (act_i.sz != SZ_NONE);
  assign sz_o    = act_i.sz;
  assign slot_o  = act_i.slot;

endmodule

// File: rtl/prs_phv_build.sv
module prs_phv_build
  import prs_pkg::*;
#(
  parameter int unsigned N_ACT  = 10,
  parameter int unsigned N_SLOT = 8,
  localparam int unsigned HDR_W = N_SLOT * (48 + 32 + 16)
) (
  input  logic [N_ACT-1:0]             hit_i,
  input  cont_sz_e [N_ACT-1:0]         sz_i,
  input  logic [N_ACT-1:0][SLOT_W-1:0] slot_i,
  input  logic [N_ACT-1:0][WIN_W-1:0]  win_i,
  output logic [HDR_W-1:0]             hdr_o
);

  logic [N_SLOT-1:0][47:0] c6;
  logic [N_SLOT-1:0][31:0] c4;
  logic [N_SLOT-1:0][15:0] c2;

  // ascending scan: later action overrides earlier
  always_comb begin
    c6 = '0;
    c4 = '0;
    c2 = '0;
    for (int a = 0; a < N_ACT; a++) begin
      if (hit_i[a]) begin
        unique case (sz_i[a])
          SZ_6B:   c6[slot_i[a]] = win_i[a];
          SZ_4B:   c4[slot_i[a]] = win_i[a][WIN_W-1 -: 32];
          SZ_2B:   c2[slot_i[a]] = win_i[a][WIN_W-1 -: 16];
          default: ;
        endcase
      end
    end
  end

  assign hdr_o = {c6, c4, c2};

endmodule

// File: rtl/prs_hdr_parser.sv
module prs_hdr_parser
  import prs_pkg::*;
#(
  parameter int unsigned PKT_W  = 1024,
  parameter int unsigned VID_W  = 12,
  parameter int unsigned USR_W  = 128,
  parameter int unsigned MD_W   = 256,
  parameter int unsigned N_ACT  = 10,
  parameter int unsigned N_SLOT = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned ROW_W = N_ACT * ACT_W,
  localparam int unsigned HDR_W = N_SLOT * (48 + 32 + 16),
  localparam int unsigned PHV_W = HDR_W + MD_W,
  localparam int unsigned RSV_LO = VID_W + USR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [PKT_W-1:0] pkt_i,
  input  logic [VID_W-1:0] vid_i,
  input  logic [USR_W-1:0] usr_i,
  input  logic             drop_i,
  input  logic             cfg_we_i,
  input  logic [AW-1:0]    cfg_idx_i,
  input  logic [ROW_W-1:0] cfg_row_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [PHV_W-1:0] phv_o
);

  logic             adv;
  logic             acc;
  logic             s1_vld_q;
  logic [PKT_W-1:0] s1_pkt_q;
  logic [VID_W-1:0] s1_vid_q;
  logic [USR_W-1:0] s1_usr_q;
  logic             s1_drop_q;
  logic [ROW_W-1:0] s1_row;
  logic             out_vld_q;
  logic [PHV_W-1:0] phv_q;

  assign adv        = !out_vld_q || out_ready_i;
  assign in_ready_o = adv;
  assign acc        = in_valid_i && adv;

  prs_act_tbl #(
    .DEPTH (DEPTH),
    .ROW_W (ROW_W)
  ) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .waddr_i (cfg_idx_i),
    .wdata_i (cfg_row_i),
    .re_i    (acc),
    .raddr_i (vid_i[AW-1:0]),
    .rdata_o (s1_row)
  );

  // stage 1: capture packet alongside table read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q  <= 1'b0;
      s1_pkt_q  <= '0;
      s1_vid_q  <= '0;
      s1_usr_q  <= '0;
      s1_drop_q <= 1'b0;
    end else if (adv) begin
      s1_vld_q <= in_valid_i;
      if (in_valid_i) begin
        s1_pkt_q  <= pkt_i;
        s1_vid_q  <= vid_i;
        s1_usr_q  <= usr_i;
        s1_drop_q <= drop_i;
      end
    end
  end

  logic [N_ACT-1:0]             hit;
  cont_sz_e [N_ACT-1:0]         sz;
  logic [N_ACT-1:0][SLOT_W-1:0] slot;
  logic [N_ACT-1:0][WIN_W-1:0]  win;

  for (genvar a = 0; a < N_ACT; a++) begin : g_act
    prs_field_pick #(
      .PKT_W (PKT_W)
    ) u_pick (
      .act_i  (parse_act_t'(s1_row[a*ACT_W +: ACT_W])),
      .pkt_i  (s1_pkt_q),
      .hit_o  (hit[a]),
      .sz_o   (sz[a]),
      .slot_o (slot[a]),
      .win_o  (win[a])
    );
  end

  logic [HDR_W-1:0] hdr;
  logic [MD_W-1:0]  md;

  prs_phv_build #(
    .N_ACT  (N_ACT),
    .N_SLOT (N_SLOT)
  ) u_build (
    .hit_i  (hit),
    .sz_i   (sz),
    .slot_i (slot),
    .win_i  (win),
    .hdr_o  (hdr)
  );

  always_comb begin
    md = '0;
    md[USR_W-1:0]            = s1_usr_q;
    md[USR_W]                = s1_drop_q;
    md[USR_W+1 +: VID_W]     = s1_vid_q;
  end

  // stage 2: output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q <= 1'b0;
      phv_q     <= '0;
    end else if (adv) begin
      out_vld_q <= s1_vld_q;
      if (s1_vld_q) phv_q <= {hdr, md};
    end
  end

  assign out_valid_o = out_vld_q;
  assign phv_o       = phv_q;

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !out_valid_o);

  // R2
  accept_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> s1_vld_q);

  // R9
  cfg_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !out_valid_o) |-> in_ready_o);

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(phv_o)));

  // R7
  md_rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (phv_o[MD_W-1:RSV_LO] == '0));

endmodule

// File: tb/prs_hdr_parser_tb.sv
module prs_hdr_parser_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1023:0] pkt = '0;
  logic [11:0]   vid = '0;
  logic [127:0]  usr = '0;
  logic          drop = 1'b0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_idx = '0;
  logic [159:0]  cfg_row = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [1023:0] phv;

  prs_hdr_parser dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .pkt_i       (pkt),
    .vid_i       (vid),
    .usr_i       (usr),
    .drop_i      (drop),
    .cfg_we_i    (cfg_we),
    .cfg_idx_i   (cfg_idx),
    .cfg_row_i   (cfg_row),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .phv_o       (phv)
  );

  int checks = 0;
  int errors = 0;
  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [159:0] mdl_tbl [16];

  typedef struct {
    logic [1023:0] phv;
    int unsigned   tag;
    bit            lat_ok;
    string         req;
  } item_t;
  item_t sb_q [$];

  bit bp_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [1023:0] act, input logic [1023:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_act(input int off, input int sz, input int slot, input bit v);
    return {3'b000, 7'(off), 2'(sz), 3'(slot), v};
  endfunction

  function automatic logic [1023:0] model(input logic [1023:0] p, input logic [11:0] v,
                                          input logic [127:0] u, input logic d);
    logic [1023:0] r;
    logic [159:0]  row;
    r = '0;
    r[140:129] = v;
    r[128]     = d;
    r[127:0]   = u;
    row = mdl_tbl[v[3:0]];
    for (int a = 0; a < 10; a++) begin
      logic [15:0] act;
      logic [47:0] w;
      int off, s;
      act = row[16*a +: 16];
      off = int'(act[12:6]);
      s   = int'(act[3:1]);
      for (int b = 0; b < 6; b++) begin
        int k;
        k = off + b;
        w[47-8*b -: 8] = (k < 128) ? p[1023-8*k -: 8] : 8'h00;
      end
      if (act[0]) begin
        case (act[5:4])
          2'b01: r[256+16*s +: 16] = w[47:32];
          2'b10: r[384+32*s +: 32] = w[47:16];
          2'b11: r[640+48*s +: 48] = w;
          default: ;
        endcase
      end
    end
    return r;
  endfunction

  task automatic cfg_write(input logic [3:0] idx, input logic [159:0] row);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_idx = idx;
    cfg_row = row;
    #1;
    if (!out_valid) chk(in_ready, "R9", {1023'b0, in_ready}, 1024'd1);
    @(posedge clk);
    #1 cfg_we = 1'b0;
    mdl_tbl[idx] = row;
  endtask

  task automatic send(input logic [1023:0] p, input logic [11:0] v, input logic [127:0] u,
                      input logic d, input string req);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    pkt = p; vid = v; usr = u; drop = d;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    it.phv = model(p, v, u, d);
    it.tag = cyc;
    it.lat_ok = !bp_mode;
    it.req = req;
    sb_q.push_back(it);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  function automatic logic [1023:0] rnd_pkt();
    logic [1023:0] r;
    for (int i = 0; i < 32; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  task automatic drain();
    int n = 0;
    while (sb_q.size() != 0 && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  // backpressure driver
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_mode ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  bit prev_stall = 1'b0;
  logic [1023:0] prev_phv;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        chk(out_valid && (phv == prev_phv), "R10", phv, prev_phv);
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R2 unexpected output", phv, '0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          chk(phv === it.phv, it.req, phv, it.phv);
          if (it.lat_ok)
            chk(cyc - it.tag == 2, "R2 latency", 1024'(cyc - it.tag), 1024'd2);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_phv   = phv;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [159:0] row;
    logic [1023:0] p;
    for (int i = 0; i < 16; i++) mdl_tbl[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(!out_valid && in_ready, "R1", {1022'b0, out_valid, in_ready}, 1024'd1);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(!out_valid, "R1", {1023'b0, out_valid}, '0);

    // R1: empty table gives header zero
    send(rnd_pkt(), 12'h009, 128'h1234, 1'b0, "R1 R6 empty row");

    // tenant 3: one action per class, one invalid, one size-less
    row = '0;
    row[16*0 +: 16] = mk_act(14, 3, 7, 1);
    row[16*1 +: 16] = mk_act(0, 2, 0, 1);
    row[16*2 +: 16] = mk_act(2, 1, 5, 1);
    row[16*3 +: 16] = mk_act(20, 1, 1, 0);   // invalid
    row[16*4 +: 16] = mk_act(30, 0, 2, 1);   // size 00
    row[16*5 +: 16] = {3'b111, 7'd40, 2'b10, 3'd6, 1'b1}; // reserved bits set
    cfg_write(4'd3, row);
    p = rnd_pkt();
    send(p, 12'h003, 128'hA5A5, 1'b0, "R3 R4 R5 R6");
    send(p, 12'h013, 128'h5A5A, 1'b1, "R8 R7");

    // tenant 5: tail past end, overlapping target
    row = '0;
    row[16*0 +: 16] = mk_act(126, 3, 3, 1);
    row[16*1 +: 16] = mk_act(10, 2, 4, 1);
    row[16*2 +: 16] = mk_act(20, 2, 4, 1);
    row[16*9 +: 16] = mk_act(127, 1, 0, 1);
    cfg_write(4'd5, row);
    send(rnd_pkt(), 12'h005, '1, 1'b0, "R11 R12");
    send(rnd_pkt(), 12'hFF5, 128'd7, 1'b1, "R8 R7 R11");
    send(rnd_pkt(), 12'h007, 128'd9, 1'b1, "R7 R6");

    // rewrite tenant 3; later packet sees new row
    row = '0;
    row[16*0 +: 16] = mk_act(5, 1, 7, 1);
    cfg_write(4'd3, row);
    send(p, 12'h003, 128'd3, 1'b0, "R9 rewrite");
    drain();

    // back-to-back random traffic
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 10; j++) row[16*j +: 16] = 16'($urandom);
      cfg_write(4'(i), row);
    end
    for (int i = 0; i < 20; i++)
      send(rnd_pkt(), 12'($urandom), {4{32'($urandom)}}, 1'($urandom), "R2 R3 R12");
    drain();

    // backpressure
    bp_mode = 1'b1;
    for (int i = 0; i < 30; i++)
      send(rnd_pkt(), 12'($urandom), {4{32'($urandom)}}, 1'($urandom), "R10 R2 order");
    drain();
    bp_mode = 1'b0;
    drain();
    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R2 drained", 1024'(sb_q.size()), '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule